// File: doc/BRIEF.md
# Audio Interrupt Status Aggregator

This block holds the pending-interrupt state of three audio stream engines: two playback streams and one record stream. Each engine sends a single-cycle "count expired" pulse when its sample counter runs out. The block records that pulse as a pending bit, provided that stream's interrupt enable is on. It presents a 32-bit status word and drives one level-sensitive interrupt line towards the host.

Software does not clear a pending bit by writing to the status word. A pending bit is removed only when a write to the serial control register turns that stream's enable from on to off. The block therefore keeps its own copy of the three enable bits taken from every serial control write.

The status word also carries some bits the block does not own. These are fixed or passed straight through: the serial UART and voice-interrupt flags, a fixed voice-source code, and the two codec busy flags. The block also keeps a sticky per-stream flag. It records that an expiry arrived while the previous interrupt of that stream was still pending and enabled, so that interrupt was lost.

Top module: `audio_irq_aggr`

## Requirements
- R1: After reset, every pending bit, every lost flag, every enable and the interrupt output are 0. With all pass-through inputs low, the status word reads 0x0000_0060.
- R2: Status bit 0 is the record stream's pending bit, bit 1 is playback stream 2's and bit 2 is playback stream 1's. The `expire` bit with the same index sets the matching pending bit on the next clock edge when that stream's enable is on.
- R3: An expiry pulse for a stream whose enable is off leaves its pending bit and its lost flag unchanged.
- R4: Status bit 31 is 1 exactly when at least one of status bits 2:0 is 1. The UART and voice-interrupt bits have no effect on it.
- R5: `irq` is registered. It equals the value status bit 31 had one clock cycle earlier.
- R6: In serial control, bit 8 is the enable of playback stream 1, bit 9 the enable of playback stream 2 and bit 10 the enable of the record stream. A write that turns an enable from 1 to 0 clears that stream's pending bit. A write that leaves an enable at 1, leaves it at 0 or turns it on does not change any pending bit.
- R7: An expiry is judged against the enable in force before a serial control write in the same cycle. If a disabling write and an expiry for the same stream arrive together, the pending bit ends up 0. If an enabling write and an expiry arrive together, the pending bit stays 0.
- R8: An expiry for a stream that is both pending and enabled sets that stream's lost flag (`lost` bit index equals the status bit index) and keeps the pending bit at 1. A lost flag stays at 1 until reset.
- R9: Status bit 3 is `uart_pend` and bit 4 is `ccb_pend`. Bits 6:5 are the fixed voice code (3 by default). Bit 8 is `codec_wr_busy`, bit 9 is `codec_busy` and bit 10 is their OR. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sctl_we | input | 1 | Serial control write strobe, one cycle per write |
| sctl_wdata | input | 32 | Serial control write data; bits 10:8 are the interrupt enables |
| expire | input | 3 | Count-expired pulses: bit 0 record, bit 1 playback 2, bit 2 playback 1 |
| uart_pend | input | 1 | Serial UART interrupt flag, passed to status bit 3 |
| ccb_pend | input | 1 | Voice interrupt flag, passed to status bit 4 |
| codec_busy | input | 1 | Codec busy flag, passed to status bit 9 |
| codec_wr_busy | input | 1 | Codec write-in-progress flag, passed to status bit 8 |
| status | output | 32 | Status word |
| irq | output | 1 | Level interrupt line, one cycle behind status bit 31 |
| lost | output | 3 | Sticky lost-interrupt flags, same bit order as status bits 2:0 |

## Verification
The pending logic is tried with expiries on enabled streams, one at a time and together. This separates bit positions and shows the channels do not interfere. It is also tried with expiries on disabled streams, which separates an enable-gated set from an ungated one.

Serial control writes are applied as enable falls, holds and rises. This tells the edge-triggered clear apart from a level clear, and from a clear that wrongly happens on re-enable. Writes that coincide with an expiry fix the priority between clear and set, and show which enable value the set uses. A repeated expiry on a pending stream, followed by disables and a later reset, separates the sticky lost flag from one that follows the pending bit.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

    localparam int STAT_W       = 32;
    localparam int NUM_SRC      = 3;
    localparam int POS_UART     = 3;
    localparam int POS_CCB      = 4;
    localparam int POS_VOICE_LO = 5;
    localparam int VOICE_W      = 2;
    localparam int POS_WR_BUSY  = 8;
    localparam int POS_BUSY     = 9;
    localparam int POS_CSTAT    = 10;
    localparam int POS_SUMMARY  = 31;

    // Per-stream interrupt state.
    typedef struct packed {
        logic en;
        logic pend;
        logic lost;
    } src_state_t;

endpackage

// File: rtl/irq_src_slice.sv
module irq_src_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic en_wr,
    input  logic evt,
    output logic pend_o,
    output logic lost_o
);
    import audio_irq_pkg::*;

    src_state_t st_d, st_q;
    logic       falling_en;

    always_comb begin
        st_d       = st_q;
        falling_en = wr_en && st_q.en && !en_wr;
        // Expiry is judged against the enable already held.
        if (evt && st_q.en) begin
            if (st_q.pend) begin
                st_d.lost = 1'b1;
            end
            st_d.pend = 1'b1;
        end
        if (wr_en) begin
            st_d.en = en_wr;
        end
        // A disabling write wins over a same-cycle set.
        if (falling_en) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign lost_o = st_q.lost;

    AST_SET_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && st_q.en && !(wr_en && !en_wr)) |=> pend_o); // R2
    AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !(evt && st_q.en)) |=> !pend_o); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.en && !en_wr) |=> !pend_o); // R6
    AST_LOST_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && st_q.en && pend_o) |=> lost_o); // R8
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |=> lost_o); // R8

endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack #(
    parameter logic [1:0] VOICE_CODE = 2'd3
) (
    input  logic [audio_irq_pkg::NUM_SRC-1:0] pend,
    input  logic                              uart_pend,
    input  logic                              ccb_pend,
    input  logic                              codec_busy,
    input  logic                              codec_wr_busy,
    output logic [audio_irq_pkg::STAT_W-1:0]  status
);
    import audio_irq_pkg::*;

    always_comb begin
        status                                   = '0;
        status[NUM_SRC-1:0]                      = pend;
        status[POS_UART]                         = uart_pend;
        status[POS_CCB]                          = ccb_pend;
        status[POS_VOICE_LO +: VOICE_W]          = VOICE_CODE;
        status[POS_WR_BUSY]                      = codec_wr_busy;
        status[POS_BUSY]                         = codec_busy;
        status[POS_CSTAT]                        = codec_busy | codec_wr_busy;
        status[POS_SUMMARY]                      = |pend;
    end

endmodule

// File: rtl/audio_irq_aggr.sv
module audio_irq_aggr #(
    parameter int         EN_BASE    = 8,
    parameter logic [1:0] VOICE_CODE = 2'd3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sctl_we,
    input  logic [31:0] sctl_wdata,
    input  logic [2:0]  expire,
    input  logic        uart_pend,
    input  logic        ccb_pend,
    input  logic        codec_busy,
    input  logic        codec_wr_busy,
    output logic [31:0] status,
    output logic        irq,
    output logic [2:0]  lost
);
    import audio_irq_pkg::*;

    localparam int EN_TOP = EN_BASE + NUM_SRC - 1;

    typedef struct packed {
        logic irq;
    } top_state_t;

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] en_field;
    top_state_t         top_d, top_q;
    logic               unused_sctl;

    assign en_field    = sctl_wdata[EN_TOP:EN_BASE];
    assign unused_sctl = ^{sctl_wdata[STAT_W-1:EN_TOP+1], sctl_wdata[EN_BASE-1:0]};

    // Status index i takes enable bit EN_TOP - i (playback 1 lowest).
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_slice u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sctl_we),
            .en_wr  (en_field[NUM_SRC-1-i]),
            .evt    (expire[i]),
            .pend_o (pend[i]),
            .lost_o (lost[i])
        );
    end

    irq_status_pack #(.VOICE_CODE(VOICE_CODE)) u_pack (
        .pend          (pend),
        .uart_pend     (uart_pend),
        .ccb_pend      (ccb_pend),
        .codec_busy    (codec_busy),
        .codec_wr_busy (codec_wr_busy),
        .status        (status)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = status[POS_SUMMARY];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq = top_q.irq;

    AST_IRQ_LAGS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|pend)); // R5
    AST_SUMMARY_FROM_CHANNELS: assert property (@(posedge clk) disable iff (!rst_n)
        status[POS_SUMMARY] == (pend != '0)); // R4

endmodule

// File: tb/audio_irq_aggr_test.sv
module audio_irq_aggr_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sctl_we = 1'b0;
    logic [31:0] sctl_wdata = '0;
    logic [2:0]  expire = '0;
    logic        uart_pend = 1'b0;
    logic        ccb_pend = 1'b0;
    logic        codec_busy = 1'b0;
    logic        codec_wr_busy = 1'b0;
    logic [31:0] status;
    logic        irq;
    logic [2:0]  lost;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_irq_aggr uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sctl_we       (sctl_we),
        .sctl_wdata    (sctl_wdata),
        .expire        (expire),
        .uart_pend     (uart_pend),
        .ccb_pend      (ccb_pend),
        .codec_busy    (codec_busy),
        .codec_wr_busy (codec_wr_busy),
        .status        (status),
        .irq           (irq),
        .lost          (lost)
    );

    function automatic logic [31:0] exp_status(input logic [2:0] p);
        logic [31:0] s;
        s       = '0;
        s[2:0]  = p;
        s[3]    = uart_pend;
        s[4]    = ccb_pend;
        s[6:5]  = 2'd3;
        s[8]    = codec_wr_busy;
        s[9]    = codec_busy;
        s[10]   = codec_busy | codec_wr_busy;
        s[31]   = |p;
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_sctl(input logic [31:0] v, input logic [2:0] ev);
        sctl_we = 1'b1; sctl_wdata = v; expire = ev;
        step();
        sctl_we = 1'b0; expire = '0;
    endtask

    task automatic pulse(input logic [2:0] ev);
        expire = ev;
        step();
        expire = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 status", status, 32'h0000_0060);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 lost", {29'b0, lost}, 32'd0);
    endtask

    task automatic t_set_enabled();
        wr_sctl(32'h0000_0700, 3'b000);
        check("R6 enable rise no set", status, exp_status(3'b000));
        pulse(3'b001);
        check("R2 record bit0", status, exp_status(3'b001));
        check("R5 irq still low", {31'b0, irq}, 32'd0);
        step();
        check("R5 irq one cycle later", {31'b0, irq}, 32'd1);
        pulse(3'b110);
        check("R2 playback bits 2:1", status, exp_status(3'b111));
        check("R8 no lost on first", {29'b0, lost}, 32'd0);
    endtask

    task automatic t_lost();
        pulse(3'b001);
        check("R8 lost record", {29'b0, lost}, 32'b001);
        check("R8 pending kept", status, exp_status(3'b111));
    endtask

    task automatic t_disable_clears();
        wr_sctl(32'h0000_0600, 3'b000);
        check("R6 playback1 cleared", status, exp_status(3'b011));
        wr_sctl(32'h0000_0600, 3'b000);
        check("R6 hold writes no change", status, exp_status(3'b011));
    endtask

    task automatic t_disabled_ignored();
        pulse(3'b100);
        check("R3 disabled expiry ignored", status, exp_status(3'b011));
        check("R3 lost unchanged", {29'b0, lost}, 32'b001);
    endtask

    task automatic t_disable_all();
        wr_sctl(32'h0000_0000, 3'b000);
        check("R6 all cleared", status, exp_status(3'b000));
        check("R5 irq lags fall", {31'b0, irq}, 32'd1);
        step();
        check("R5 irq low", {31'b0, irq}, 32'd0);
        check("R8 lost sticky", {29'b0, lost}, 32'b001);
    endtask

    task automatic t_same_cycle();
        wr_sctl(32'h0000_0400, 3'b000);
        wr_sctl(32'h0000_0000, 3'b001);
        check("R7 disable wins", status, exp_status(3'b000));
        wr_sctl(32'h0000_0200, 3'b010);
        check("R7 enable same cycle no set", status, exp_status(3'b000));
        pulse(3'b010);
        check("R2 playback2 after enable", status, exp_status(3'b010));
        wr_sctl(32'h0000_0000, 3'b000);
    endtask

    task automatic t_passthrough();
        uart_pend = 1'b1; ccb_pend = 1'b1;
        step();
        check("R4 uart/ccb no summary", status, exp_status(3'b000));
        check("R4 irq stays low", {31'b0, irq}, 32'd0);
        uart_pend = 1'b0; ccb_pend = 1'b0; codec_busy = 1'b1;
        step();
        check("R9 codec busy", status, 32'h0000_0660);
        codec_busy = 1'b0; codec_wr_busy = 1'b1;
        step();
        check("R9 codec write busy", status, 32'h0000_0560);
        codec_wr_busy = 1'b0;
    endtask

    task automatic t_reset_clears_lost();
        do_reset();
        check("R8 reset clears lost", {29'b0, lost}, 32'd0);
        pulse(3'b001);
        check("R1 enables off after reset", status, exp_status(3'b000));
    endtask

    initial begin
        t_reset();
        t_set_enabled();
        t_lost();
        t_disable_clears();
        t_disabled_ignored();
        t_disable_all();
        t_same_cycle();
        t_passthrough();
        t_reset_clears_lost();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule